// File: doc/BRIEF.md
# NIC DMA Interrupt Status Register

This block collects the event pulses that a network controller's receive and transmit DMA engines raise. It holds each one in a sticky status flag until software clears it. The DMA logic feeds it single-cycle pulses for frame start, each long word moved to host memory, frame completion, receive error and transmit FIFO underflow. It also feeds a level that tells whether any receive buffer is currently available.

Software reaches the block through a plain register port with two addresses. Address 0 returns the status flags, and writing ones there clears them. Address 1 holds the interrupt enables, the early-receive enable and the early-receive long-word threshold. A registered, active-low interrupt line is driven from the status flags and the enables. Two one-cycle handshake pulses go back to the receive engine: one tells it to suspend when buffers run out, and one tells it to abort the frame after an error.

No data stream crosses this block, so it has no valid/ready interface. Every pin is a plain control or status signal, and the register port accepts a write in any cycle in which `reg_wr` is high.

Top module: `nic_irq_status`

## Requirements
- R1: After reset, both registers read 0, `irq_n` is 1 and `rx_suspend` and `rx_abort` are 0.
- R2: Status at address 0 uses these bits: 7 buffer-unavailable, 6 receive-complete, 5 transmit-underflow, 4 receive-error, 3 early-receive. All other bits read 0. Control at address 1 uses these fields: bits 7:3 are interrupt enables for the same-numbered status bits, bits 15:8 are the early threshold, and bit 16 is the early-receive enable.
- R3: Buffer-unavailable never sets while `rx_buf_present` has stayed 0 since reset. It sets in the cycle after `rx_buf_present` drops from 1 to 0.
- R4: When buffer-unavailable is raised by such a transition, `rx_suspend` is high for exactly one cycle, visible in the same cycle the flag becomes visible.
- R5: Writing 1 to a status bit at address 0 clears it, however many events hit it while set. Writing 0 to a bit leaves it unchanged.
- R6: If an event and a write-one-to-clear hit the same bit in one cycle, the bit stays set.
- R7: An `rx_done` pulse sets receive-complete.
- R8: With the early-receive enable on, early-receive sets when the `rx_word` count since the last `rx_frame_start` equals the threshold. It fires at most once per frame. With the enable off it never sets.
- R9: Early-receive clears in the same cycle that receive-complete or receive-error becomes set.
- R10: An `rx_err` pulse sets receive-error and gives a one-cycle `rx_abort` pulse in the following cycle.
- R11: A `tx_underflow` pulse sets transmit-underflow.
- R12: `irq_n` goes low one cycle after an enabled status bit is set. It stays high while only masked bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_buf_present | input | 1 | Level: at least one receive buffer is available |
| rx_frame_start | input | 1 | Pulse: a new incoming frame begins |
| rx_word | input | 1 | Pulse: one long word moved to host memory |
| rx_done | input | 1 | Pulse: frame status written back |
| rx_err | input | 1 | Pulse: receive error after partial transfer |
| tx_underflow | input | 1 | Pulse: transmit FIFO underflow |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Registered active-low interrupt |
| rx_suspend | output | 1 | Pulse: receive engine must suspend |
| rx_abort | output | 1 | Pulse: receive engine must drop the frame |

## Verification
The bench holds the buffer level low from reset to show that buffer-unavailable does not fire without a prior buffer. A design that tested only the level would raise it at once. The bench keeps pulsing words after the threshold and keeps the frame running after a software clear. A design that compared with greater-or-equal would set early-receive again. The bench collides an event with a clear of the same bit, which shows whether a design lets the clear win and loses the event. It also ends a frame while early-receive is set, which exposes a design that leaves the stale early flag standing next to the completion flag.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int RBU_B   = 7;
  localparam int RXC_B   = 6;
  localparam int TXU_B   = 5;
  localparam int RXE_B   = 4;
  localparam int ERL_B   = 3;
  localparam int STAT_LO = 3;
  localparam int STAT_N  = 5;
  localparam int THR_LSB = 8;
endpackage

// File: rtl/nic_irq_rbu_detect.sv
// Detects the step from "some buffer" to "no buffer". The held sample
// starts at 0, so an empty ring after reset cannot produce an event.
module nic_irq_rbu_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  output logic lost
);
  logic present_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= 1'b0;
    else        present_q <= present;
  end

  assign lost = present_q & ~present;
endmodule

// File: rtl/nic_irq_word_track.sv
// Counts long words of the current frame and flags the word whose
// count equals the threshold; equality keeps it to one hit per frame.
module nic_irq_word_track #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             word,
  input  logic             enable,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (frame_start) cnt_q <= '0;
    else if (word)        cnt_q <= cnt_nxt;
  end

  assign hit = enable & word & ~frame_start & (thr != '0) &
               (cnt_nxt == CNT_W'(thr));
endmodule

// File: rtl/nic_irq_sticky.sv
// Bank of sticky flags: a set beats every clear in the same cycle.
module nic_irq_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
  import nic_irq_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_buf_present,
  input  logic              rx_frame_start,
  input  logic              rx_word,
  input  logic              rx_done,
  input  logic              rx_err,
  input  logic              tx_underflow,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n,
  output logic              rx_suspend,
  output logic              rx_abort
);
  localparam int ERLEN_B = THR_LSB + THR_W;
  localparam int STAT_HI = STAT_LO + STAT_N - 1;

  logic [STAT_N-1:0] en_q;
  logic [THR_W-1:0]  thr_q;
  logic              erl_en_q;
  logic [STAT_N-1:0] stat_q;
  logic [STAT_N-1:0] set_v;
  logic [STAT_N-1:0] clr_v;
  logic              rbu_evt;
  logic              early_hit;
  logic              frame_end;
  logic              wr_stat;
  logic              wr_ctrl;

  assign wr_stat = reg_wr & ~reg_addr;
  assign wr_ctrl = reg_wr &  reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      thr_q    <= '0;
      erl_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q     <= reg_wdata[STAT_HI:STAT_LO];
      thr_q    <= reg_wdata[THR_LSB +: THR_W];
      erl_en_q <= reg_wdata[ERLEN_B];
    end
  end

  nic_irq_rbu_detect u_rbu (
    .clk     (clk),
    .rst_n   (rst_n),
    .present (rx_buf_present),
    .lost    (rbu_evt)
  );

  nic_irq_word_track #(.CNT_W(CNT_W), .THR_W(THR_W)) u_words (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (rx_frame_start),
    .word        (rx_word),
    .enable      (erl_en_q),
    .thr         (thr_q),
    .hit         (early_hit)
  );

  assign frame_end = rx_done | rx_err;

  always_comb begin
    set_v = '0;
    set_v[RBU_B-STAT_LO] = rbu_evt;
    set_v[RXC_B-STAT_LO] = rx_done;
    set_v[TXU_B-STAT_LO] = tx_underflow;
    set_v[RXE_B-STAT_LO] = rx_err;
    set_v[ERL_B-STAT_LO] = early_hit & ~frame_end;
    clr_v = wr_stat ? reg_wdata[STAT_HI:STAT_LO] : '0;
    clr_v[ERL_B-STAT_LO] = clr_v[ERL_B-STAT_LO] | frame_end;
  end

  nic_irq_sticky #(.N(STAT_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_v),
    .clr   (clr_v),
    .q     (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n      <= 1'b1;
      rx_suspend <= 1'b0;
      rx_abort   <= 1'b0;
    end else begin
      irq_n      <= ~|(stat_q & en_q);
      rx_suspend <= rbu_evt;
      rx_abort   <= rx_err;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[STAT_HI:STAT_LO] = stat_q;
    end else begin
      reg_rdata[STAT_HI:STAT_LO]   = en_q;
      reg_rdata[THR_LSB +: THR_W]  = thr_q;
      reg_rdata[ERLEN_B]           = erl_en_q;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[DATA_W-1:ERLEN_B+1], reg_wdata[STAT_LO-1:0]};
endmodule

// File: rtl/nic_irq_status_chk.sv
module nic_irq_status_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_done,
  input logic         rx_err,
  input logic         tx_underflow,
  input logic         reg_wr,
  input logic         reg_addr,
  input logic [31:0]  reg_wdata,
  input logic [N-1:0] stat_q,
  input logic [N-1:0] en_q,
  input logic         irq_n,
  input logic         rx_abort
);
  // R7
  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> stat_q[3]);
  // R9
  p_early_autoclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done || rx_err) |=> !stat_q[0]);
  // R10
  p_abort_follows_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> (rx_abort && stat_q[1]));
  // R6 / R11
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> stat_q[2]);
  // R5
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[2] && !(reg_wr && !reg_addr && reg_wdata[5])) |=> stat_q[2]);
  // R12
  p_irq_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q)) |=> !irq_n);
endmodule

bind nic_irq_status nic_irq_status_chk #(.N(5)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_done      (rx_done),
  .rx_err       (rx_err),
  .tx_underflow (tx_underflow),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .stat_q       (stat_q),
  .en_q         (en_q),
  .irq_n        (irq_n),
  .rx_abort     (rx_abort)
);

// File: tb/nic_irq_status_bench.sv
`timescale 1ns/1ps
module nic_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_buf_present = 1'b0, rx_frame_start = 1'b0, rx_word = 1'b0;
  logic rx_done = 1'b0, rx_err = 1'b0, tx_underflow = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_n, rx_suspend, rx_abort;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nic_irq_status u_nic_irq_status (
    .clk(clk), .rst_n(rst_n), .rx_buf_present(rx_buf_present),
    .rx_frame_start(rx_frame_start), .rx_word(rx_word), .rx_done(rx_done),
    .rx_err(rx_err), .tx_underflow(tx_underflow), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_n(irq_n), .rx_suspend(rx_suspend), .rx_abort(rx_abort));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(); s = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input logic erl, input logic [7:0] thr, input logic [7:0] en);
    return {15'b0, erl, thr, en};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); check("R1 status", v, 0);
    rd(1, v); check("R1 ctrl", v, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 pulses", {rx_suspend, rx_abort}, 0);
  endtask

  task automatic t_rbu();
    logic [31:0] v;
    repeat (4) step();
    rd(0, v); check("R3 no arm", v, 0);
    rx_buf_present = 1'b1; repeat (3) step();
    rx_buf_present = 1'b0; step();
    rd(0, v); check("R3 set", v, 32'h80);
    check("R2 R4 suspend", rx_suspend, 1);
    step();
    check("R4 one cycle", rx_suspend, 0);
    wr(0, 32'h80);
    rd(0, v); check("R5 clear rbu", v, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    repeat (3) pulse(tx_underflow);
    pulse(rx_done);
    rd(0, v); check("R11 R7 set", v, 32'h60);
    wr(0, 32'h00);
    rd(0, v); check("R5 zero write", v, 32'h60);
    wr(0, 32'h20);
    rd(0, v); check("R5 one clear", v, 32'h40);
    wr(0, 32'h40);
    rd(0, v); check("R5 cleared", v, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    tx_underflow = 1'b1;
    wr(0, 32'h20);
    tx_underflow = 1'b0;
    rd(0, v); check("R6 set wins", v, 32'h20);
    wr(0, 32'h20);
  endtask

  task automatic t_early();
    logic [31:0] v;
    wr(1, ctrl(1, 8'd4, 8'h00));
    pulse(rx_frame_start);
    repeat (3) pulse(rx_word);
    rd(0, v); check("R8 below", v, 0);
    pulse(rx_word);
    rd(0, v); check("R8 reach", v, 32'h08);
    wr(0, 32'h08);
    repeat (4) pulse(rx_word);
    rd(0, v); check("R8 once", v, 0);
    pulse(rx_frame_start);
    repeat (4) pulse(rx_word);
    pulse(rx_done);
    rd(0, v); check("R9 done clears", v, 32'h40);
    wr(0, 32'h40);
    pulse(rx_frame_start);
    repeat (4) pulse(rx_word);
    rx_err = 1'b1; step(); rx_err = 1'b0;
    rd(0, v); check("R9 R10 err clears", v, 32'h10);
    check("R10 abort", rx_abort, 1);
    step(); check("R10 abort once", rx_abort, 0);
    wr(0, 32'h10);
    wr(1, ctrl(0, 8'd4, 8'h00));
    pulse(rx_frame_start);
    repeat (5) pulse(rx_word);
    rd(0, v); check("R8 disabled", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, ctrl(0, 8'd0, 8'h20));
    rd(1, v); check("R2 ctrl", v, 32'h20);
    pulse(rx_done);
    step(); check("R12 masked", irq_n, 1);
    tx_underflow = 1'b1; step(); tx_underflow = 1'b0;
    check("R12 not yet", irq_n, 1);
    step(); check("R12 low", irq_n, 0);
    wr(1, ctrl(0, 8'd0, 8'h00));
    step(); check("R12 masked off", irq_n, 1);
    wr(0, 32'hF8);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_rbu();
    t_w1c();
    t_setwins();
    t_early();
    t_irq();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule